// File: doc/BRIEF.md
# Parallel NOR Flash Command-Set Model

This block is a synthesizable stand-in for a parallel NOR flash device. It sits on a simple synchronous bus with a byte address, a write word, a read word, read and write strobes, a read-only strap and an endianness input. Behind the bus is a small byte array built from a few uniform sectors. The array holds 0xFF out of reset.

Bus writes are not stored directly. Each write is taken as one cycle of a multi-cycle command protocol. The low byte of the write word is the opcode or the confirm code. The command currently active decides what a read returns:

- array data,
- the 8-bit status register,
- an identifier word, or
- a byte from the query table.

The protocol covers single-word program, sector erase, buffered program, lock and unlock, status read and clear, identifier read and the query window. Lock and unlock are accepted but have no effect on the array.

Sector erase runs one byte per clock. While an erase is running, bus writes are ignored. Every access is one full bus word, taken from the address aligned down to the word size. Whether the lowest-addressed byte lands in the most significant lane or the least significant lane is chosen by `big_endian`.

Top module: `nor_flash_model`

## Requirements
- R1: After reset the device is in read-array mode with a cleared status register, and every array word reads 0xFF in each byte.
- R2: In read-array mode a read returns the bus word at the address aligned down to the word size. With `big_endian` high, the lowest-addressed byte is in bits [DW-1:DW-8]. With it low, that byte is in bits [7:0]. A read with `rd_en` low returns 0.
- R3: Opcode 0x10 or 0x40 followed by a data write stores that word at the aligned address, sets status bit 7 and returns to read-array mode. When `read_only` is high, the array is left unchanged and status bit 4 is set as well.
- R4: Opcode 0x20 selects the sector that holds the address and fills it with 0xFF, one byte per clock. While the erase runs, status bit 7 reads 0 and reads return the status register. Bus writes during the erase have no effect. Bit 7 becomes 1 when the last byte of the sector is cleared.
- R5: In the write after an erase, 0xD0 keeps status-read mode with bit 7 set. Any other value, including 0xFF, returns to read-array mode.
- R6: With `read_only` high, opcode 0x20 erases nothing and sets status bits 5 and 7.
- R7: Opcode 0x60 followed by 0xD0 or 0x01 leaves the device in status-read mode with bit 7 set. Any other second value returns to read-array mode. The array is unchanged either way.
- R8: After opcode 0x70, and while the active command is 0x20, 0x60 or 0xE8, reads return the status register zero-extended to the bus width.
- R9: Opcode 0x50 clears all status bits and returns to read-array mode.
- R10: After opcode 0x90, the word index is the low 8 address bits divided by the bus width in bytes. Index 0 reads the manufacturer code, index 1 reads the device code, and any other index reads 0.
- R11: After opcode 0x98, the same word index selects a query table byte. Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59. Index 0x27 holds log2 of the array size in bytes, index 0x2C holds 1, and index 0x2D holds the sector count minus 1. Indices at or above 0x3D read 0. A write of 0xFF leaves the query mode, and any other write keeps it.
- R12: Opcode 0xE8 sets status bit 7 and is followed by a count N. The next N+1 writes each store their word at their own aligned address. After those writes, 0xD0 leaves status-read mode with bit 7 set, and any other value returns to read-array mode. With `read_only` high, the array is left unchanged and status bit 4 is set.
- R13: Any idle-stage opcode not listed above returns to read-array mode and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address |
| wdata | input | DW | Write word; the low byte carries opcodes and confirm codes |
| wr_en | input | 1 | Write strobe, one command cycle per high clock |
| rd_en | input | 1 | Read strobe; `rdata` is 0 while low |
| rdata | output | DW | Read word, combinational from state and address |
| read_only | input | 1 | Strap: program and erase report errors instead of writing |
| big_endian | input | 1 | Byte order of multi-byte accesses |

## Verification
A wrong command or stage register shows up at the very next read. The read mux then picks array data where status, identifier or query data is due, or the reverse. Because of this, a sequence error becomes visible within one clock, provided the bench reads every cycle.

A wrong erase pointer or busy flag behaves differently. During the erase it shows only as status bit 7 timing. After the erase it shows as bytes that were not cleared, or were cleared in the wrong sector. Those only appear when the affected words are read back.

Lane-order faults stay invisible until a word is read with the opposite `big_endian` setting from the one used to write it.

// File: rtl/nfm_pkg.sv
package nfm_pkg;

    typedef enum logic [1:0] {
        STG_IDLE    = 2'd0,
        STG_ARG     = 2'd1,
        STG_DATA    = 2'd2,
        STG_CONFIRM = 2'd3
    } stage_e;

    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_NONE     = 8'h00;
    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFFER   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    localparam logic [7:0] QUERY_LEN = 8'h3D;

    function automatic logic [7:0] query_entry(input logic [7:0] idx,
                                               input int size_log2,
                                               input int buf_log2,
                                               input int sect_bytes,
                                               input int num_sect);
        logic [7:0] v;
        v = 8'h00;
        case (idx)
            8'h10: v = 8'h51;
            8'h11: v = 8'h52;
            8'h12: v = 8'h59;
            8'h13: v = 8'h01;
            8'h15: v = 8'h31;
            8'h1B: v = 8'h45;
            8'h1C: v = 8'h55;
            8'h1F: v = 8'h07;
            8'h20: v = 8'h07;
            8'h21: v = 8'h0A;
            8'h23: v = 8'h04;
            8'h24: v = 8'h04;
            8'h25: v = 8'h04;
            8'h27: v = 8'(size_log2);
            8'h28: v = 8'h02;
            8'h2A: v = 8'(buf_log2);
            8'h2C: v = 8'h01;
            8'h2D: v = 8'(num_sect - 1);
            8'h2E: v = 8'((num_sect - 1) >> 8);
            8'h2F: v = 8'(sect_bytes >> 8);
            8'h30: v = 8'(sect_bytes >> 16);
            8'h31: v = 8'h50;
            8'h32: v = 8'h52;
            8'h33: v = 8'h49;
            8'h34: v = 8'h31;
            8'h35: v = 8'h31;
            default: v = 8'h00;
        endcase
        if (idx >= QUERY_LEN) begin
            v = 8'h00;
        end
        return v;
    endfunction

endpackage

// File: rtl/nfm_lane_order.sv
// Maps between array byte order (byte i = lowest address + i in bits 8i+7:8i)
// and bus lane order. The mapping is its own inverse, so one module serves
// both the write and the read direction.
module nfm_lane_order #(
    parameter int NB = 2
) (
    input  logic            big_endian,
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign dout[8*g +: 8] = big_endian ? din[8*(NB-1-g) +: 8] : din[8*g +: 8];
    end

endmodule

// File: rtl/nfm_store.sv
module nfm_store #(
    parameter int NBYTES = 256,
    parameter int NB     = 2,
    parameter int AW     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_we,
    input  logic [AW-1:0]   word_base,
    input  logic [NB*8-1:0] word_bytes,
    input  logic            byte_we,
    input  logic [AW-1:0]   byte_addr,
    input  logic [AW-1:0]   rd_base,
    output logic [NB*8-1:0] rd_bytes
);

    logic [7:0] mem_q [NBYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NBYTES; k++) begin
                mem_q[k] <= 8'hFF;
            end
        end else begin
            if (word_we) begin
                for (int i = 0; i < NB; i++) begin
                    mem_q[word_base + AW'(i)] <= word_bytes[8*i +: 8];
                end
            end
            if (byte_we) begin
                mem_q[byte_addr] <= 8'hFF;
            end
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_rd
        assign rd_bytes[8*g +: 8] = mem_q[rd_base + AW'(g)];
    end

endmodule

// File: rtl/nfm_info_rom.sv
module nfm_info_rom
    import nfm_pkg::*;
#(
    parameter int          SIZE_LOG2  = 8,
    parameter int          BUF_LOG2   = 5,
    parameter int          SECT_BYTES = 64,
    parameter int          NUM_SECT   = 4,
    parameter logic [15:0] MFR_CODE   = 16'h00A7,
    parameter logic [15:0] DEV_CODE   = 16'h5C31
) (
    input  logic [7:0]  idx,
    output logic [15:0] ident,
    output logic [7:0]  qbyte
);

    always_comb begin
        case (idx)
            8'h00:   ident = MFR_CODE;
            8'h01:   ident = DEV_CODE;
            default: ident = 16'h0000;
        endcase
    end

    assign qbyte = query_entry(idx, SIZE_LOG2, BUF_LOG2, SECT_BYTES, NUM_SECT);

endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model
    import nfm_pkg::*;
#(
    parameter int          BUS_BYTES  = 2,
    parameter int          SECT_BYTES = 64,
    parameter int          NUM_SECT   = 4,
    parameter int          BUF_LOG2   = 5,
    parameter logic [15:0] MFR_CODE   = 16'h00A7,
    parameter logic [15:0] DEV_CODE   = 16'h5C31,
    localparam int         TOTAL      = SECT_BYTES * NUM_SECT,
    localparam int         AW         = $clog2(TOTAL),
    localparam int         DW         = 8 * BUS_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    input  logic          read_only,
    input  logic          big_endian
);

    localparam int            WSHIFT    = $clog2(BUS_BYTES);
    localparam logic [AW-1:0] WORD_MASK = ~AW'(BUS_BYTES - 1);
    localparam logic [AW-1:0] SECT_MASK = ~AW'(SECT_BYTES - 1);

    typedef struct packed {
        stage_e        stage;
        logic [7:0]    cmd;
        logic [7:0]    status;
        logic [7:0]    count;
        logic          busy;
        logic [AW-1:0] eptr;
    } ctl_t;

    ctl_t q, d;

    logic          word_we;
    logic          byte_we;
    logic [AW-1:0] word_base;
    logic [AW-1:0] byte_addr;
    logic [DW-1:0] wr_bytes;
    logic [DW-1:0] rd_bytes;
    logic [DW-1:0] rd_word;
    logic [7:0]    op;
    logic [7:0]    addr_lo;
    logic [7:0]    info_idx;
    logic [15:0]   ident;
    logic [7:0]    qbyte;

    assign word_base = addr & WORD_MASK;
    assign op        = wdata[7:0];
    assign addr_lo   = 8'(addr);
    assign info_idx  = addr_lo >> WSHIFT;

    nfm_lane_order #(.NB(BUS_BYTES)) u_wr_lanes (
        .big_endian (big_endian),
        .din        (wdata),
        .dout       (wr_bytes)
    );

    nfm_lane_order #(.NB(BUS_BYTES)) u_rd_lanes (
        .big_endian (big_endian),
        .din        (rd_bytes),
        .dout       (rd_word)
    );

    nfm_store #(.NBYTES(TOTAL), .NB(BUS_BYTES), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (word_we),
        .word_base  (word_base),
        .word_bytes (wr_bytes),
        .byte_we    (byte_we),
        .byte_addr  (byte_addr),
        .rd_base    (word_base),
        .rd_bytes   (rd_bytes)
    );

    nfm_info_rom #(
        .SIZE_LOG2  (AW),
        .BUF_LOG2   (BUF_LOG2),
        .SECT_BYTES (SECT_BYTES),
        .NUM_SECT   (NUM_SECT),
        .MFR_CODE   (MFR_CODE),
        .DEV_CODE   (DEV_CODE)
    ) u_info (
        .idx   (info_idx),
        .ident (ident),
        .qbyte (qbyte)
    );

    // Next-state logic for the command protocol and the erase walker.
    always_comb begin
        d         = q;
        word_we   = 1'b0;
        byte_we   = 1'b0;
        byte_addr = q.eptr;
        if (q.busy) begin
            // Erase in progress: clear one byte per clock, ignore the bus.
            byte_we = 1'b1;
            d.eptr  = q.eptr + 1'b1;
            if ((q.eptr | SECT_MASK) == '1) begin
                d.busy             = 1'b0;
                d.status[ST_READY] = 1'b1;
            end
        end else if (wr_en) begin
            case (q.stage)
                STG_IDLE: begin
                    d.cmd   = op;
                    d.stage = STG_ARG;
                    case (op)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                        end
                        OP_ERASE: begin
                            if (read_only) begin
                                d.status[ST_ERASE_ERR] = 1'b1;
                                d.status[ST_READY]     = 1'b1;
                            end else begin
                                d.busy             = 1'b1;
                                d.eptr             = addr & SECT_MASK;
                                d.status[ST_READY] = 1'b0;
                            end
                        end
                        OP_BUFFER: begin
                            d.status[ST_READY] = 1'b1;
                        end
                        OP_STATUS, OP_IDENT: begin
                            d.stage = STG_IDLE;
                        end
                        OP_CLEAR: begin
                            d.status = 8'h00;
                            d.cmd    = OP_NONE;
                            d.stage  = STG_IDLE;
                        end
                        default: begin
                            // 0xFF, 0x00 and unknown opcodes: back to array reads
                            d.cmd   = OP_NONE;
                            d.stage = STG_IDLE;
                        end
                    endcase
                end
                STG_ARG: begin
                    case (q.cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            if (read_only) begin
                                d.status[ST_PROG_ERR] = 1'b1;
                            end else begin
                                word_we = 1'b1;
                            end
                            d.status[ST_READY] = 1'b1;
                            d.cmd              = OP_NONE;
                            d.stage            = STG_IDLE;
                        end
                        OP_ERASE: begin
                            d.stage = STG_IDLE;
                            if (op == OP_CONFIRM) begin
                                d.status[ST_READY] = 1'b1;
                            end else begin
                                d.cmd = OP_NONE;
                            end
                        end
                        OP_LOCK: begin
                            d.stage = STG_IDLE;
                            if (op == OP_CONFIRM || op == OP_LOCK_ALT) begin
                                d.status[ST_READY] = 1'b1;
                            end else begin
                                d.cmd = OP_NONE;
                            end
                        end
                        OP_BUFFER: begin
                            d.count = op;
                            d.stage = STG_DATA;
                        end
                        OP_QUERY: begin
                            if (op == OP_ARRAY) begin
                                d.cmd   = OP_NONE;
                                d.stage = STG_IDLE;
                            end
                        end
                        default: begin
                            d.cmd   = OP_NONE;
                            d.stage = STG_IDLE;
                        end
                    endcase
                end
                STG_DATA: begin
                    if (read_only) begin
                        d.status[ST_PROG_ERR] = 1'b1;
                    end else begin
                        word_we = 1'b1;
                    end
                    d.status[ST_READY] = 1'b1;
                    if (q.count == 8'h00) begin
                        d.stage = STG_CONFIRM;
                    end
                    d.count = q.count - 8'h01;
                end
                STG_CONFIRM: begin
                    d.stage = STG_IDLE;
                    if (op == OP_CONFIRM) begin
                        d.status[ST_READY] = 1'b1;
                    end else begin
                        d.cmd = OP_NONE;
                    end
                end
                default: begin
                    d.cmd   = OP_NONE;
                    d.stage = STG_IDLE;
                end
            endcase
        end
    end

    // Read data selection by active command.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (q.cmd)
                OP_ERASE, OP_CLEAR, OP_LOCK, OP_STATUS, OP_BUFFER: rdata = DW'(q.status);
                OP_IDENT: rdata = DW'(ident);
                OP_QUERY: rdata = DW'(qbyte);
                default:  rdata = rd_word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nfm_checker.sv
module nfm_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    op,
    input logic [DW-1:0] rdata,
    input logic          read_only,
    input logic          busy,
    input logic [7:0]    status,
    input logic [7:0]    cmd,
    input logic [1:0]    stage,
    input logic          word_we
);

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !status[7]); // R4

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |-> (rdata == DW'(status))); // R4

    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd)); // R4

    AST_RO_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (read_only && !busy) |-> !word_we); // R3

    AST_BUF_STAGE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage >= 2'd2) |-> (cmd == 8'hE8)); // R12

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && stage == 2'd0 && op == 8'h50) |=> (status == 8'h00)); // R9

endmodule

bind nor_flash_model nfm_checker #(.DW(DW)) u_nfm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .op        (wdata[7:0]),
    .rdata     (rdata),
    .read_only (read_only),
    .busy      (q.busy),
    .status    (q.status),
    .cmd       (q.cmd),
    .stage     (q.stage),
    .word_we   (word_we)
);

// File: tb/nor_flash_model_tb_top.sv
module nor_flash_model_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 2;
    localparam int SECT  = 64;
    localparam int NSECT = 4;
    localparam int TOTAL = SECT * NSECT;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int MFR   = 16'h00A7;
    localparam int DEV   = 16'h5C31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;
    logic          read_only = 1'b0;
    logic          big_endian = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    int m_mem [TOTAL];
    int m_stage, m_cmd, m_status, m_cnt, m_busy_left, m_eptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_flash_model dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rdata      (rdata),
        .read_only  (read_only),
        .big_endian (big_endian)
    );

    function automatic bit is_status_cmd(int c);
        return c == 'h20 || c == 'h50 || c == 'h60 || c == 'h70 || c == 'hE8;
    endfunction

    function automatic int query_ref(int idx);
        if (idx >= 'h3D) return 0;
        case (idx)
            'h10: return 'h51;
            'h11: return 'h52;
            'h12: return 'h59;
            'h27: return 8;
            'h2C: return 1;
            'h2D: return NSECT - 1;
            default: return 0;
        endcase
    endfunction

    function automatic int model_read(bit r, int a);
        int base, v, idx;
        if (!r) return 0;
        idx = (a & 'hFF) / NB;
        if (is_status_cmd(m_cmd)) return m_status;
        if (m_cmd == 'h90) return (idx == 0) ? MFR : (idx == 1) ? DEV : 0;
        if (m_cmd == 'h98) return query_ref(idx);
        base = a - (a % NB);
        v = 0;
        for (int i = 0; i < NB; i++) begin
            if (big_endian) v = v | (m_mem[base+i] << (8*(NB-1-i)));
            else            v = v | (m_mem[base+i] << (8*i));
        end
        return v;
    endfunction

    function automatic string mode_tag();
        if (m_busy_left > 0) return "R4";
        if (is_status_cmd(m_cmd)) return "R8";
        if (m_cmd == 'h90) return "R10";
        if (m_cmd == 'h98) return "R11";
        return "R2";
    endfunction

    task automatic model_store(int a, int dv);
        int base;
        base = a - (a % NB);
        for (int i = 0; i < NB; i++) begin
            if (big_endian) m_mem[base+i] = (dv >> (8*(NB-1-i))) & 'hFF;
            else            m_mem[base+i] = (dv >> (8*i)) & 'hFF;
        end
    endtask

    task automatic to_array();
        m_cmd = 0;
        m_stage = 0;
    endtask

    task automatic model_tick(bit w, int a, int dv);
        int op;
        op = dv & 'hFF;
        if (m_busy_left > 0) begin
            m_mem[m_eptr] = 'hFF;
            m_eptr++;
            m_busy_left--;
            if (m_busy_left == 0) m_status = m_status | 'h80;
            return;
        end
        if (!w) return;
        if (m_stage == 0) begin
            if (op == 'h10 || op == 'h40 || op == 'h60 || op == 'h98) begin
                m_cmd = op; m_stage = 1;
            end else if (op == 'h20) begin
                m_cmd = op; m_stage = 1;
                if (read_only) m_status = m_status | 'hA0;
                else begin
                    m_busy_left = SECT;
                    m_eptr = a - (a % SECT);
                    m_status = m_status & 'h7F;
                end
            end else if (op == 'hE8) begin
                m_cmd = op; m_stage = 1; m_status = m_status | 'h80;
            end else if (op == 'h70 || op == 'h90) begin
                m_cmd = op;
            end else if (op == 'h50) begin
                m_status = 0; to_array();
            end else begin
                to_array();
            end
        end else if (m_stage == 1) begin
            if (m_cmd == 'h10 || m_cmd == 'h40) begin
                if (read_only) m_status = m_status | 'h10;
                else model_store(a, dv);
                m_status = m_status | 'h80;
                to_array();
            end else if (m_cmd == 'h20) begin
                if (op == 'hD0) begin m_stage = 0; m_status = m_status | 'h80; end
                else to_array();
            end else if (m_cmd == 'h60) begin
                if (op == 'hD0 || op == 'h01) begin m_stage = 0; m_status = m_status | 'h80; end
                else to_array();
            end else if (m_cmd == 'hE8) begin
                m_cnt = op; m_stage = 2;
            end else if (m_cmd == 'h98) begin
                if (op == 'hFF) to_array();
            end else begin
                to_array();
            end
        end else if (m_stage == 2) begin
            if (read_only) m_status = m_status | 'h10;
            else model_store(a, dv);
            m_status = m_status | 'h80;
            if (m_cnt == 0) m_stage = 3;
            m_cnt = (m_cnt - 1) & 'hFF;
        end else begin
            if (op == 'hD0) begin m_stage = 0; m_status = m_status | 'h80; end
            else to_array();
        end
    endtask

    task automatic step(bit r, bit w, int a, int dv, string tag);
        int exp;
        string t;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = AW'(a); wdata = DW'(dv);
        #1;
        exp = model_read(r, a);
        t = (tag == "") ? mode_tag() : tag;
        n_chk++;
        if (rdata !== DW'(exp)) begin
            n_fail++;
            $display("FAIL %s: addr %h rdata %h expected %h", t, a, rdata, DW'(exp));
        end
        @(posedge clk);
        model_tick(w, a, dv);
    endtask

    task automatic wr(int a, int dv);
        step(1'b0, 1'b1, a, dv, "");
    endtask

    task automatic rd(int a, string tag);
        step(1'b1, 1'b0, a, 0, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < TOTAL; i++) m_mem[i] = 'hFF;
        m_stage = 0; m_cmd = 0; m_status = 0; m_cnt = 0; m_busy_left = 0; m_eptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: erased array and clear status after reset
        rd('h00, "R1");
        rd('hFE, "R1");
        wr('h00, 'h70);
        rd('h00, "R1");
        wr('h00, 'hFF);
        step(1'b0, 1'b0, 0, 0, "R2");

        // R3, R2: program with both opcodes, read in both lane orders
        big_endian = 1'b0;
        wr('h10, 'h40);
        wr('h10, 'hA55A);
        rd('h10, "R3");
        rd('h11, "R3");
        big_endian = 1'b1;
        rd('h10, "R2");
        wr('h20, 'h10);
        wr('h20, 'h1234);
        rd('h20, "R3");
        big_endian = 1'b0;
        rd('h20, "R2");
        wr('h00, 'h70);
        rd('h00, "R8");

        // R9: clear status
        wr('h00, 'h50);
        rd('h10, "R9");
        wr('h00, 'h70);
        rd('h00, "R9");

        // R4, R5: erase sector 1 with confirm; writes during erase ignored
        wr('h44, 'h40);
        wr('h44, 'hBEEF);
        wr('h50, 'h20);
        rd('h44, "R4");
        wr('h00, 'hFF);
        wr('h00, 'h50);
        for (int i = 0; i < SECT + 2; i++) rd('h44, "R4");
        wr('h00, 'hD0);
        rd('h00, "R5");
        wr('h00, 'hFF);
        rd('h44, "R4");
        rd('h7E, "R4");
        rd('h10, "R4");
        rd('h80, "R4");
        // erase then 0xFF and erase then junk
        wr('h80, 'h40);
        wr('h82, 'h7777);
        wr('h82, 'h20);
        for (int i = 0; i < SECT + 1; i++) step(1'b0, 1'b0, 0, 0, "R4");
        wr('h00, 'hFF);
        rd('h82, "R5");
        wr('h00, 'h20);
        for (int i = 0; i < SECT + 1; i++) step(1'b0, 1'b0, 0, 0, "R4");
        wr('h00, 'h33);
        rd('h10, "R5");

        // R6, R3, R12: read-only strap
        read_only = 1'b1;
        wr('h20, 'h40);
        wr('h30, 'h1111);
        rd('h30, "R3");
        wr('h00, 'h50);
        wr('h30, 'h10);
        wr('h30, 'h2222);
        wr('h00, 'h70);
        rd('h00, "R3");
        wr('h00, 'h50);
        wr('hC0, 'h20);
        rd('h00, "R6");
        wr('h00, 'hD0);
        wr('h00, 'hFF);
        rd('hC0, "R6");
        wr('h00, 'h50);
        wr('hC0, 'hE8);
        wr('hC0, 'h00);
        wr('hC0, 'h9999);
        rd('hC0, "R12");
        wr('hC0, 'hD0);
        rd('hC0, "R12");
        wr('h00, 'hFF);
        rd('hC0, "R12");
        read_only = 1'b0;

        // R7: lock / unlock
        wr('h00, 'h50);
        wr('h10, 'h60);
        rd('h10, "R7");
        wr('h10, 'h01);
        rd('h10, "R7");
        wr('h00, 'hFF);
        wr('h00, 'h60);
        wr('h00, 'hD0);
        rd('h00, "R7");
        wr('h00, 'h60);
        wr('h00, 'h55);
        rd('h10, "R7");

        // R10: identifier
        wr('h00, 'h90);
        rd('h00, "R10");
        rd('h01, "R10");
        rd('h02, "R10");
        rd('h04, "R10");
        rd('hFE, "R10");
        wr('h00, 'hFF);

        // R11: query window
        wr('h00, 'h98);
        rd('h20, "R11");
        rd('h22, "R11");
        rd('h24, "R11");
        rd('h4E, "R11");
        rd('h58, "R11");
        rd('h5A, "R11");
        rd('h7A, "R11");
        rd('hFE, "R11");
        wr('h00, 'h70);
        rd('h20, "R11");
        wr('h00, 'hFF);
        rd('h20, "R11");

        // R12: buffered program with confirm, then aborted confirm
        big_endian = 1'b1;
        wr('h00, 'h50);
        wr('hC0, 'hE8);
        rd('hC0, "R12");
        wr('hC0, 'h02);
        wr('hC0, 'h0102);
        wr('hC2, 'h0304);
        wr('hC4, 'h0506);
        rd('hC0, "R12");
        wr('hC0, 'hD0);
        rd('hC0, "R12");
        wr('h00, 'hFF);
        rd('hC0, "R12");
        rd('hC2, "R12");
        rd('hC4, "R12");
        rd('hC6, "R12");
        wr('hC8, 'hE8);
        wr('hC8, 'h00);
        wr('hC8, 'hABCD);
        wr('hC8, 'h77);
        rd('hC8, "R12");
        big_endian = 1'b0;

        // R13: unknown opcode
        wr('h00, 'h50);
        wr('h00, 'h40);
        wr('h00, 'h0F0F);
        wr('h00, 'h70);
        wr('h00, 'h42);
        rd('h00, "R13");
        wr('h00, 'h70);
        rd('h00, "R13");
        wr('h00, 'hFF);
        rd('h00, "R13");

        summary();
    end

endmodule